// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is a free-running watchdog that software arms, feeds and configures through a small 32-bit register port. Counting runs on a separate slow clock so that the timer keeps going when the bus clock is gated for debug. A 16-bit key written to the key register does three jobs: it opens or closes write access to the configuration registers, it starts the timer, and it feeds (reloads) it. Once the timer is started, it cannot be stopped except by reset. When the down-counter runs out, the block emits a one-slow-cycle reset request, reloads and carries on.

The block can also give an early warning. A compare value is set in the early-warning control register. When the down-counter steps onto that value, a pending flag is set. That flag, gated by an enable bit, drives a registered interrupt. Every configuration value crosses into the slow domain through its own toggle handshake. A status bit for each register stays high until the new value is in force, and a register whose update is still crossing ignores further writes.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the prescaler reads 0, the reload value reads 0xFFF, early-warning control reads 0, status reads 0, and both `irq` and `rst_req` are low.
- R2: A write of 0x5555 to the key register (offset 0x000, upper 16 bits zero) grants write access to the prescaler (0x004), reload (0x008) and early-warning control (0x014) registers. A write of 0x0000 withdraws it. While access is withdrawn, writes to those three registers leave their contents unchanged. The reload field keeps only its 12 low bits.
- R3: Any key value other than 0x0000, 0x5555, 0xAAAA or 0xCCCC changes nothing: access stays as it was, and the timer does not start.
- R4: Key 0xCCCC starts the timer, and status bit 8 then reads 1. No later key write clears it; only reset does.
- R5: Prescaler code p divides the slow clock by 4·2^p. Codes above 6 act as 6 (divide by 256). While running, `rst_req` pulses high for exactly one slow cycle every (reload+1)·divide slow cycles.
- R6: Key 0xAAAA reloads the counter and restarts the prescaler, so feeding more often than the timeout keeps `rst_req` low.
- R7: Status bits 0 to 3 flag pending prescaler, reload, compare and early-warning-enable updates. Each bit goes high from the write until the value is in force in the slow domain. A write to a register whose bit is high is ignored.
- R8: The early-warning flag (status bit 15) sets when the counter steps onto the compare value (early-warning control bits 11:0). `irq` is that flag ANDed with the enable bit (early-warning control bit 15).
- R9: Writing 1 to bit 15 of the clear register (0x018), or to bit 14 of early-warning control, clears the flag, with or without write access. A write to early-warning control without access leaves its other fields unchanged.
- R10: Any write to early-warning control while write access is granted also reloads the counter, as a feed does.
- R11: The version register (0x3F4) reads the revision parameter (default 0x40) in its low 8 bits and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst | input | 1 | Synchronous active-high reset for both clock domains |
| slow_clk | input | 1 | Counting clock |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for `addr`, one clock later |
| irq | output | 1 | Early-warning interrupt, bus domain |
| rst_req | output | 1 | Expiry pulse, one slow cycle wide |

## Verification
The checks assume three things about the inputs. Reset is held across several slow-clock edges. The slow clock is several times slower than the bus clock. Software waits for the status busy bits to fall before it relies on a new setting. The stimulus holds reset for sixteen bus cycles and polls the status register until all busy bits are clear after every configuration write. It spaces feed and control writes further apart than one command round trip, so no feed is dropped by a crossing that is still in flight. The one exception is a deliberate back-to-back reload write, used to show that a second write during a pending update is discarded.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_LOCK   = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

  localparam int OFS_KEY = 'h000;
  localparam int OFS_PRE = 'h004;
  localparam int OFS_RLD = 'h008;
  localparam int OFS_STS = 'h00C;
  localparam int OFS_EWC = 'h014;
  localparam int OFS_ICR = 'h018;
  localparam int OFS_VER = 'h3F4;

  // status / control bit positions
  localparam int STS_RUN  = 8;
  localparam int STS_FLAG = 15;
  localparam int EWC_EN   = 15;
  localparam int EWC_CLR  = 14;
  localparam int ICR_CLR  = 15;

  // data crossing channels (status bits 0..3 in this order)
  localparam int NCH    = 4;
  localparam int CH_PRE = 0;
  localparam int CH_RLD = 1;
  localparam int CH_CMP = 2;
  localparam int CH_EWE = 3;

  // command crossing channels
  localparam int NCMD      = 3;
  localparam int CMD_START = 0;
  localparam int CMD_FEED  = 1;
  localparam int CMD_CLR   = 2;
endpackage

// File: rtl/kwd_xfer.sv
// Carries a configuration value from the bus domain into the slow domain.
// The held copy doubles as the software-visible register contents.
module kwd_xfer #(
  parameter int W = 12,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst,
  input  logic         launch,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] held,
  output logic [W-1:0] dst_q
);
  logic tog, ack1, ack2;
  logic s1, s2, s3;

  assign busy = tog ^ ack2;

  always_ff @(posedge src_clk) begin
    if (rst) begin
      tog  <= 1'b0;
      ack1 <= 1'b0;
      ack2 <= 1'b0;
      held <= INIT;
    end else begin
      ack1 <= s3;
      ack2 <= ack1;
      if (launch && !busy) begin
        tog  <= ~tog;
        held <= din;
      end
    end
  end

  always_ff @(posedge dst_clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      dst_q <= INIT;
    end else begin
      s1 <= tog;
      s2 <= s1;
      s3 <= s2;
      if (s2 ^ s3) dst_q <= held;
    end
  end
endmodule

// File: rtl/kwd_cmdx.sv
// Single-event crossing; a request made while one is in flight is dropped.
module kwd_cmdx (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst,
  input  logic launch,
  output logic dst_pulse
);
  logic tog, ack1, ack2;
  logic s1, s2, s3;

  always_ff @(posedge src_clk) begin
    if (rst) begin
      tog  <= 1'b0;
      ack1 <= 1'b0;
      ack2 <= 1'b0;
    end else begin
      ack1 <= s3;
      ack2 <= ack1;
      if (launch && (tog == ack2)) tog <= ~tog;
    end
  end

  always_ff @(posedge dst_clk) begin
    if (rst) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      dst_pulse <= 1'b0;
    end else begin
      s1        <= tog;
      s2        <= s1;
      s3        <= s2;
      dst_pulse <= s2 ^ s3;
    end
  end
endmodule

// File: rtl/kwd_core.sv
// Slow-domain counting engine.
module kwd_core #(
  parameter int PRE_W    = 4,
  parameter int CNT_W    = 12,
  parameter int MAX_CODE = 6
) (
  input  logic             slow_clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ew_en,
  input  logic             start_p,
  input  logic             feed_p,
  input  logic             clr_p,
  output logic             running,
  output logic             ew_flag,
  output logic             irq_s,
  output logic             rst_req
);
  localparam int DIV_W = MAX_CODE + 2;

  logic [PRE_W-1:0] code;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] plim, pcnt;
  logic [CNT_W-1:0] cnt;
  logic             refresh, tick, hit, flag_n;

  always_comb begin
    code    = (pre_code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : pre_code;
    span    = (DIV_W+1)'(1) << (code + PRE_W'(2));
    plim    = DIV_W'(span - 1'b1);
    refresh = running && (start_p || feed_p);
    tick    = running && !refresh && (pcnt == plim);
    hit     = tick && (cnt != '0) && ((cnt - 1'b1) == cmp);
    flag_n  = clr_p ? 1'b0 : (hit ? 1'b1 : ew_flag);
  end

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      running <= 1'b0;
      pcnt    <= '0;
      cnt     <= '0;
      ew_flag <= 1'b0;
      irq_s   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      ew_flag <= flag_n;
      irq_s   <= flag_n & ew_en;
      if (start_p && !running) begin
        running <= 1'b1;
        cnt     <= reload;
        pcnt    <= '0;
      end else if (refresh) begin
        cnt  <= reload;
        pcnt <= '0;
      end else if (tick) begin
        pcnt <= '0;
        if (cnt == '0) begin
          rst_req <= 1'b1;
          cnt     <= reload;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (running) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwd_regs.sv
// Bus-domain register file: key decode, access gate, read mux.
module kwd_regs import kwd_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4,
  parameter int CNT_W  = 12,
  parameter logic [7:0] REV = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    busy,
  input  logic [PRE_W-1:0]  pre_q,
  input  logic [CNT_W-1:0]  rld_q,
  input  logic [CNT_W-1:0]  cmp_q,
  input  logic              ewe_q,
  input  logic              run_a,
  input  logic              flag_a,
  input  logic              irq_a,
  output logic [NCH-1:0]    ld,
  output logic [NCMD-1:0]   cmd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              unlocked
);
  logic [2:0] m1, m2;   // {irq, flag, running} synchronisers
  logic       wr_key, cfg_wr;
  logic [KEY_W-1:0] key;

  assign irq = m2[2];

  always_comb begin
    key    = wdata[KEY_W-1:0];
    wr_key = wr_en && (addr == ADDR_W'(OFS_KEY)) && (wdata[DATA_W-1:KEY_W] == '0);
    cfg_wr = wr_en && unlocked;
    ld     = '0;
    if (cfg_wr) begin
      if (addr == ADDR_W'(OFS_PRE)) ld[CH_PRE] = 1'b1;
      if (addr == ADDR_W'(OFS_RLD)) ld[CH_RLD] = 1'b1;
      if (addr == ADDR_W'(OFS_EWC)) begin
        ld[CH_CMP] = 1'b1;
        ld[CH_EWE] = 1'b1;
      end
    end
    cmd[CMD_START] = wr_key && (key == KEY_START);
    cmd[CMD_FEED]  = (wr_key && (key == KEY_FEED)) ||
                     (cfg_wr && (addr == ADDR_W'(OFS_EWC)));
    cmd[CMD_CLR]   = wr_en && (((addr == ADDR_W'(OFS_ICR)) && wdata[ICR_CLR]) ||
                               ((addr == ADDR_W'(OFS_EWC)) && wdata[EWC_CLR]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      m1       <= '0;
      m2       <= '0;
    end else begin
      m1 <= {irq_a, flag_a, run_a};
      m2 <= m1;
      if (wr_key) begin
        if (key == KEY_UNLOCK)    unlocked <= 1'b1;
        else if (key == KEY_LOCK) unlocked <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        ADDR_W'(OFS_PRE): rdata[PRE_W-1:0] <= pre_q;
        ADDR_W'(OFS_RLD): rdata[CNT_W-1:0] <= rld_q;
        ADDR_W'(OFS_STS): begin
          rdata[NCH-1:0]  <= busy;
          rdata[STS_RUN]  <= m2[0];
          rdata[STS_FLAG] <= m2[1];
        end
        ADDR_W'(OFS_EWC): begin
          rdata[CNT_W-1:0] <= cmp_q;
          rdata[EWC_EN]    <= ewe_q;
        end
        ADDR_W'(OFS_VER): rdata[7:0] <= REV;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog import kwd_pkg::*; #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 4,
  parameter int CNT_W    = 12,
  parameter int MAX_CODE = 6,
  parameter logic [7:0] REV = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  logic [NCH-1:0]   ld, busy_w;
  logic [NCMD-1:0]  cmd, cmd_p;
  logic [PRE_W-1:0] held_pre, q_pre;
  logic [CNT_W-1:0] held_rld, q_rld, held_cmp, q_cmp;
  logic             held_ewe, q_ewe;
  logic             run_slow, flag_slow, irq_slow, unlocked_w;

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W), .REV(REV)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy_w), .pre_q(held_pre), .rld_q(held_rld), .cmp_q(held_cmp), .ewe_q(held_ewe),
    .run_a(run_slow), .flag_a(flag_slow), .irq_a(irq_slow),
    .ld(ld), .cmd(cmd), .rdata(rdata), .irq(irq), .unlocked(unlocked_w)
  );

  kwd_xfer #(.W(PRE_W), .INIT({PRE_W{1'b0}})) u_x_pre (
    .src_clk(clk), .dst_clk(slow_clk), .rst(rst), .launch(ld[CH_PRE]),
    .din(wdata[PRE_W-1:0]), .busy(busy_w[CH_PRE]), .held(held_pre), .dst_q(q_pre)
  );
  kwd_xfer #(.W(CNT_W), .INIT({CNT_W{1'b1}})) u_x_rld (
    .src_clk(clk), .dst_clk(slow_clk), .rst(rst), .launch(ld[CH_RLD]),
    .din(wdata[CNT_W-1:0]), .busy(busy_w[CH_RLD]), .held(held_rld), .dst_q(q_rld)
  );
  kwd_xfer #(.W(CNT_W), .INIT({CNT_W{1'b0}})) u_x_cmp (
    .src_clk(clk), .dst_clk(slow_clk), .rst(rst), .launch(ld[CH_CMP]),
    .din(wdata[CNT_W-1:0]), .busy(busy_w[CH_CMP]), .held(held_cmp), .dst_q(q_cmp)
  );
  kwd_xfer #(.W(1), .INIT(1'b0)) u_x_ewe (
    .src_clk(clk), .dst_clk(slow_clk), .rst(rst), .launch(ld[CH_EWE]),
    .din(wdata[EWC_EN]), .busy(busy_w[CH_EWE]), .held(held_ewe), .dst_q(q_ewe)
  );

  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    kwd_cmdx u_c (
      .src_clk(clk), .dst_clk(slow_clk), .rst(rst),
      .launch(cmd[g]), .dst_pulse(cmd_p[g])
    );
  end

  kwd_core #(.PRE_W(PRE_W), .CNT_W(CNT_W), .MAX_CODE(MAX_CODE)) u_core (
    .slow_clk(slow_clk), .rst(rst), .pre_code(q_pre), .reload(q_rld), .cmp(q_cmp),
    .ew_en(q_ewe), .start_p(cmd_p[CMD_START]), .feed_p(cmd_p[CMD_FEED]),
    .clr_p(cmd_p[CMD_CLR]), .running(run_slow), .ew_flag(flag_slow),
    .irq_s(irq_slow), .rst_req(rst_req)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             slow_clk,
  input logic             rst,
  input logic             unlocked,
  input logic [PRE_W-1:0] pre_held,
  input logic [CNT_W-1:0] rld_held,
  input logic             busy_rld,
  input logic             running,
  input logic             rst_req
);
  // R2: without write access the prescaler contents cannot move
  a_r2_locked_pre_frozen: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(pre_held));

  // R7: a pending reload update blocks any new reload value
  a_r7_rld_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    busy_rld |=> $stable(rld_held));

  // R4: a started timer stays started
  a_r4_run_sticky: assert property (@(posedge slow_clk) disable iff (rst)
    running |=> running);

  // R5: expiry pulse is one slow cycle wide
  a_r5_pulse_single: assert property (@(posedge slow_clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R5: no expiry unless the timer runs
  a_r5_pulse_needs_run: assert property (@(posedge slow_clk) disable iff (rst)
    rst_req |-> running);
endmodule

bind keyed_wdog kwd_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .slow_clk(slow_clk), .rst(rst), .unlocked(unlocked_w),
  .pre_held(held_pre), .rld_held(held_rld), .busy_rld(busy_w[1]),
  .running(run_slow), .rst_req(rst_req)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int NVEC   = 9;

  logic clk = 1'b0, slow_clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq, rst_req;

  int tests = 0, fails = 0;
  int scnt = 0, last_s = 0, gap = 0, npulse = 0, wide = 0;
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;     // 200 MHz bus clock
  always #10  slow_clk = ~slow_clk;

  keyed_wdog u_keyed_wdog (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always @(posedge slow_clk) scnt <= scnt + 1;

  always @(negedge slow_clk) begin
    if (rst) begin
      npulse <= 0; wide <= 0; prev_req <= 1'b0;
    end else begin
      prev_req <= rst_req;
      if (rst_req) begin
        npulse <= npulse + 1;
        gap    <= scnt - last_s;
        last_s <= scnt;
        if (prev_req) wide <= wide + 1;
      end
    end
  end

  // {key, offset, write data, expected read-back}
  localparam logic [59:0] VEC [NVEC] = '{
    {16'h5555, 12'h004, 16'h0002, 16'h0002},  // R2 write with access
    {16'h5555, 12'h008, 16'h0123, 16'h0123},  // R2
    {16'h0000, 12'h004, 16'h0005, 16'h0002},  // R2 locked write ignored
    {16'h1234, 12'h008, 16'h0456, 16'h0123},  // R3 odd key keeps lock
    {16'h5555, 12'h014, 16'h8010, 16'h8010},  // R8 enable + compare
    {16'h0000, 12'h014, 16'h0020, 16'h8010},  // R9 locked control write
    {16'h5555, 12'h008, 16'hF3FF, 16'h03FF},  // R2 12-bit reload field
    {16'h5555, 12'h004, 16'h0003, 16'h0003},  // R2
    {16'h7777, 12'h3F4, 16'h0000, 16'h0040}   // R11 version read-only
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(12'h00C, s);
      if (s[3:0] == 4'h0) break;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (16) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_pulses(input int n);
    for (int k = 0; k < 20000 && npulse < n; k++) @(negedge clk);
  endtask

  task automatic period_case(input logic [3:0] code, input logic [11:0] rl, input int exp, input string tag);
    do_reset();
    wr(12'h000, 32'h5555);
    wr(12'h004, {28'h0, code});
    settle();
    wr(12'h008, {20'h0, rl});
    settle();
    wr(12'h000, 32'hCCCC);
    wait_pulses(3);
    chk(gap == exp, tag, gap, exp);
    chk(wide == 0, "R5 pulse one slow cycle", wide, 0);
  endtask

  task automatic wait_irq(input logic lvl);
    for (int k = 0; k < 3000 && irq !== lvl; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    rd(12'h004, d); chk(d == 32'h0,   "R1 prescaler", d, 32'h0);
    rd(12'h008, d); chk(d == 32'hFFF, "R1 reload",    d, 32'hFFF);
    rd(12'h014, d); chk(d == 32'h0,   "R1 ew control", d, 32'h0);
    rd(12'h00C, d); chk(d == 32'h0,   "R1 status",    d, 32'h0);
    chk(irq == 1'b0 && rst_req == 1'b0, "R1 outputs", {irq, rst_req}, 0);

    // table walk: R2 R3 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      wr(12'h000, {16'h0, VEC[i][59:44]});
      wr(VEC[i][43:32], {16'h0, VEC[i][31:16]});
      settle();
      rd(VEC[i][43:32], d);
      chk(d == {16'h0, VEC[i][15:0]}, $sformatf("R2/R3/R9/R11 vector %0d", i), d, {16'h0, VEC[i][15:0]});
    end

    // R3: an unknown key does not start the timer
    do_reset();
    wr(12'h000, 32'hBEEF);
    repeat (60) @(negedge clk);
    rd(12'h00C, d);
    chk(d[8] == 1'b0 && npulse == 0, "R3 odd key no start", d, 0);

    // R7: busy bit and a write dropped while pending
    wr(12'h000, 32'h5555);
    wr(12'h008, 32'h011);
    rd(12'h00C, d);
    chk(d[1] == 1'b1, "R7 reload busy set", d[1], 1);
    wr(12'h008, 32'h022);
    settle();
    rd(12'h008, d);
    chk(d == 32'h011, "R7 write during busy ignored", d, 32'h011);
    rd(12'h00C, d);
    chk(d[3:0] == 4'h0, "R7 busy clears", d[3:0], 0);

    // R5 expiry periods
    period_case(4'h0, 12'h003, 16,  "R5 div4 reload3");
    // R4 running and sticky
    rd(12'h00C, d); chk(d[8] == 1'b1, "R4 running bit", d, 32'h100);
    wr(12'h000, 32'h0000);
    wr(12'h000, 32'h1234);
    repeat (40) @(negedge clk);
    rd(12'h00C, d); chk(d[8] == 1'b1, "R4 cannot stop", d, 32'h100);
    period_case(4'h1, 12'h005, 48,  "R5 div8 reload5");
    period_case(4'hF, 12'h002, 768, "R5 code capped at 256");

    // R6 feeding keeps reset request low
    do_reset();
    wr(12'h000, 32'h5555);
    wr(12'h008, 32'h003);
    settle();
    wr(12'h000, 32'hCCCC);
    for (int k = 0; k < 12; k++) begin
      repeat (30) @(negedge clk);
      wr(12'h000, 32'hAAAA);
    end
    chk(npulse == 0, "R6 feed prevents expiry", npulse, 0);
    repeat (200) @(negedge clk);
    chk(npulse > 0, "R6 expiry after feeding stops", npulse, 1);

    // R10 unlocked control write reloads
    do_reset();
    wr(12'h000, 32'h5555);
    wr(12'h008, 32'h003);
    settle();
    wr(12'h000, 32'hCCCC);
    for (int k = 0; k < 12; k++) begin
      repeat (30) @(negedge clk);
      wr(12'h014, 32'h0000);
    end
    chk(npulse == 0, "R10 control write feeds", npulse, 0);

    // R8 / R9 early warning
    do_reset();
    wr(12'h000, 32'h5555);
    wr(12'h008, 32'h014);
    settle();
    wr(12'h014, 32'h800A);
    settle();
    wr(12'h000, 32'hCCCC);
    wait_irq(1'b1);
    chk(irq == 1'b1, "R8 irq on compare", irq, 1);
    rd(12'h00C, d); chk(d[15] == 1'b1, "R8 flag in status", d, 32'h8100);
    wr(12'h018, 32'h8000);
    repeat (25) @(negedge clk);
    rd(12'h00C, d);
    chk(irq == 1'b0 && d[15] == 1'b0, "R9 clear register", {irq, d[15]}, 0);
    wait_irq(1'b1);
    wr(12'h000, 32'h0000);
    wr(12'h014, 32'h4000);
    repeat (25) @(negedge clk);
    rd(12'h00C, d);
    chk(irq == 1'b0 && d[15] == 1'b0, "R9 clear bit while locked", {irq, d[15]}, 0);
    rd(12'h014, d);
    chk(d == 32'h800A, "R9 locked fields kept", d, 32'h800A);
    wr(12'h000, 32'h5555);
    wr(12'h014, 32'h000A);
    settle();
    repeat (20) @(negedge clk);
    for (int k = 0; k < 1500; k++) begin
      rd(12'h00C, d);
      if (d[15]) break;
    end
    chk(d[15] == 1'b1 && irq == 1'b0, "R8 masked flag gives no irq", {d[15], irq}, 32'h2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule